// File: doc/BRIEF.md
# Autobaud Low-Pulse Width Meter

This block measures how many clock cycles the serial receive line stays low, so that software can work out the line's bit rate from a known low pulse, such as the start bit of a sync character. Software arms the meter with a start bit. The meter then waits for the line to fall and counts master-clock cycles until it rises again. It latches that count into a result register, drops the start bit by itself, and raises an interrupt flag if interrupts are enabled. Turning the count into a bit rate is left to software.

A measurement that has begun cannot be cancelled. If software clears the start bit while the meter is counting, the meter stays in the counting status. Every later rising edge then raises an interrupt, but the result is not updated. Setting the start bit again lets the next rising edge finish the measurement normally. The result register always shows the last completed measurement, never the live count.

Internally a control state machine has five states. UNINIT is the state after reset. IDLE is ready and not armed. ARMED is ready and waiting for a fall. MEASURE is counting with the start bit set. DETACHED is counting with the start bit cleared by software. Its transitions are:
- wake: UNINIT to IDLE or ARMED.
- arm: IDLE to ARMED.
- disarm: ARMED to IDLE.
- go: ARMED to MEASURE on a fall.
- finish: MEASURE to IDLE on a rise.
- detach: MEASURE to DETACHED on a write with the start bit clear.
- reattach: DETACHED to MEASURE on a write with the start bit set.
- orphan-rise: DETACHED stays in DETACHED and raises an interrupt on each rise.

Top module: `autobaud_meter`

## Requirements
- R1: After reset, `state_code` is 0 (not initialised), `start_bit`, `irq_en` and `irq_flag` are 0, and `pulse_count` is 0.
- R2: `state_code` leaves 0 for 1 (ready) on the first `cfg_wr` that has `cfg_start` or `cfg_irq_en` set. It never goes back to 0. Every `cfg_wr` loads `irq_en` from `cfg_irq_en`.
- R3: A `cfg_wr` with `cfg_start`=1 while ready sets `start_bit`, and `state_code` stays 1. A falling edge on `rx_in` then moves `state_code` to 2 (counting). `state_code` never reads 3.
- R4: `rx_in` passes through a two-flop synchroniser. When `rx_in` is held low for exactly L clock cycles, the completed measurement is L. It appears on `pulse_count` three clock edges after `rx_in` returns high.
- R5: While `state_code` is 2, `pulse_count` keeps the previous completed result. It changes only when a measurement completes.
- R6: On the rising edge that ends a measurement with `start_bit` set, `state_code` returns to 1 and `start_bit` clears by itself.
- R7: `irq_flag` is set by a measurement event only when `irq_en` is 1 at that event. With `irq_en`=0 the result is still latched and `irq_flag` stays 0.
- R8: A one-cycle pulse on `irq_clr` (write-one-to-clear) clears `irq_flag`.
- R9: A `cfg_wr` with `cfg_start`=0 while counting does not abort the measurement. `state_code` stays 2, every later rising edge sets `irq_flag` (if enabled), and `pulse_count` is not updated. A later `cfg_wr` with `cfg_start`=1 lets the next rise finish normally with a new result.
- R10: A `cfg_wr` with `cfg_start`=0 while armed, before any fall, disarms the meter. A following low pulse on `rx_in` changes neither `state_code`, `pulse_count` nor `irq_flag`.
- R11: The cycle counter saturates at 2^CNT_W-1 instead of wrapping. A low pulse longer than that yields the all-ones result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also the counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| cfg_wr | input | 1 | One-cycle control write strobe |
| cfg_start | input | 1 | Start bit value for the control write |
| cfg_irq_en | input | 1 | Interrupt-enable value for the control write |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| state_code | output | 2 | 0 not initialised, 1 ready, 2 counting |
| start_bit | output | 1 | Current start bit (self-clearing) |
| irq_en | output | 1 | Current interrupt-enable bit |
| irq_flag | output | 1 | Pending interrupt; also the interrupt line |
| pulse_count | output | CNT_W | Last completed measurement in clock cycles |

## Verification
The meter is driven with low pulses of several lengths: short, medium, and longer than the counter range. Exact results separate an off-by-one in the synchroniser or counter start from correct counting, and the longest pulse separates saturation from wrap-around. A pulse is sampled in mid-flight to tell a live count from a held result. Pulses with the interrupt disabled separate the latch path from the flag path. Clearing the start bit at two points tells the rules apart: before the fall it must cancel, and after the fall it must not abort. The repeated rising edges in the detached case show an interrupt on every rise with no update of the result. A resumed measurement shows that re-setting the start bit completes it.

// File: rtl/abd_pkg.sv
package abd_pkg;

    // Externally visible status codes
    localparam logic [1:0] STAT_UNINIT   = 2'd0;
    localparam logic [1:0] STAT_READY    = 2'd1;
    localparam logic [1:0] STAT_COUNTING = 2'd2;

    // Control state machine
    typedef enum logic [2:0] {
        F_UNINIT   = 3'd0,
        F_IDLE     = 3'd1,
        F_ARMED    = 3'd2,
        F_MEASURE  = 3'd3,
        F_DETACHED = 3'd4
    } fsm_e;

endpackage

// File: rtl/abd_rx_edge.sv
module abd_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_fall,
    output logic rx_rise
);
    localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NS-1:0] sync_q;
    logic          prev_q;

    // Synchroniser chain, idle-high reset
    generate
        for (genvar g = 0; g < NS; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= rx_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[NS-1];
    end

    assign rx_fall = prev_q & ~sync_q[NS-1];
    assign rx_rise = ~prev_q & sync_q[NS-1];

endmodule

// File: rtl/abd_width_meter.sv
module abd_width_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_first,
    input  logic             run,
    input  logic             latch,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] result_q;

    // Live counter: first low cycle counts as one, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (load_first) begin
            live_q <= CNT_ONE;
        end else if (run && !latch && live_q != CNT_MAX) begin
            live_q <= live_q + CNT_ONE;
        end
    end

    // Result register holds the last completed measurement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     result_q <= '0;
        else if (latch) result_q <= live_q;
    end

    assign result = result_q;

endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
    import abd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       wr_start,
    input  logic       wr_ie,
    input  logic       fall,
    input  logic       rise,
    output logic [1:0] status,
    output logic       start,
    output logic       go,
    output logic       run,
    output logic       finish,
    output logic       event_hit
);
    fsm_e cur_q, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= F_UNINIT;
        else        cur_q <= nxt;
    end

    // Transitions and per-cycle strobes
    always_comb begin
        nxt       = cur_q;
        go        = 1'b0;
        finish    = 1'b0;
        event_hit = 1'b0;
        unique case (cur_q)
            F_UNINIT: begin
                if (wr && (wr_start || wr_ie))
                    nxt = wr_start ? F_ARMED : F_IDLE;          // wake
            end
            F_IDLE: begin
                if (wr && wr_start) nxt = F_ARMED;              // arm
            end
            F_ARMED: begin
                if (fall) begin
                    nxt = F_MEASURE;                            // go
                    go  = 1'b1;
                end else if (wr && !wr_start) begin
                    nxt = F_IDLE;                               // disarm
                end
            end
            F_MEASURE: begin
                if (rise) begin
                    nxt       = F_IDLE;                         // finish
                    finish    = 1'b1;
                    event_hit = 1'b1;
                end else if (wr && !wr_start) begin
                    nxt = F_DETACHED;                           // detach
                end
            end
            F_DETACHED: begin
                if (rise) event_hit = 1'b1;                     // orphan-rise
                if (wr && wr_start) nxt = F_MEASURE;            // reattach
            end
            default: nxt = F_UNINIT;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        status = STAT_UNINIT;
        start  = 1'b0;
        run    = 1'b0;
        unique case (cur_q)
            F_UNINIT:   status = STAT_UNINIT;
            F_IDLE:     status = STAT_READY;
            F_ARMED: begin
                status = STAT_READY;
                start  = 1'b1;
            end
            F_MEASURE: begin
                status = STAT_COUNTING;
                start  = 1'b1;
                run    = 1'b1;
            end
            F_DETACHED: begin
                status = STAT_COUNTING;
                run    = 1'b1;
            end
            default: status = STAT_UNINIT;
        endcase
    end

endmodule

// File: rtl/autobaud_meter.sv
module autobaud_meter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             cfg_wr,
    input  logic             cfg_start,
    input  logic             cfg_irq_en,
    input  logic             irq_clr,
    output logic [1:0]       state_code,
    output logic             start_bit,
    output logic             irq_en,
    output logic             irq_flag,
    output logic [CNT_W-1:0] pulse_count
);
    logic fall, rise;
    logic go, run, finish, event_hit;
    logic ie_q, flag_q;

    abd_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_in),
        .rx_fall  (fall),
        .rx_rise  (rise)
    );

    abd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wr_start  (cfg_start),
        .wr_ie     (cfg_irq_en),
        .fall      (fall),
        .rise      (rise),
        .status    (state_code),
        .start     (start_bit),
        .go        (go),
        .run       (run),
        .finish    (finish),
        .event_hit (event_hit)
    );

    abd_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (go),
        .run        (run),
        .latch      (finish),
        .result     (pulse_count)
    );

    // Interrupt enable register, loaded on each control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (cfg_wr) ie_q <= cfg_irq_en;
    end

    // Interrupt flag: set by an enabled event, write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (event_hit && ie_q) flag_q <= 1'b1;
        else if (irq_clr)           flag_q <= 1'b0;
    end

    assign irq_en   = ie_q;
    assign irq_flag = flag_q;

endmodule

// File: rtl/autobaud_meter_chk.sv
module autobaud_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_start,
    input logic             cfg_irq_en,
    input logic [1:0]       state_code,
    input logic             start_bit,
    input logic             irq_en,
    input logic             irq_flag,
    input logic [CNT_W-1:0] pulse_count
);
    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 2'd3);

    assert_stay_uninit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0 && !(cfg_wr && (cfg_start || cfg_irq_en))) |=> state_code == 2'd0);

    assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_count) |-> $past(state_code) == 2'd2);

    assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_code) == 2'd2 && state_code == 2'd1) |-> (!start_bit && $past(start_bit)));

    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_en));

    assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd2 && !start_bit) |=> state_code == 2'd2);

endmodule

bind autobaud_meter autobaud_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_start   (cfg_start),
    .cfg_irq_en  (cfg_irq_en),
    .state_code  (state_code),
    .start_bit   (start_bit),
    .irq_en      (irq_en),
    .irq_flag    (irq_flag),
    .pulse_count (pulse_count)
);

// File: tb/autobaud_meter_tb.sv
module autobaud_meter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_in = 1'b1;
    logic          cfg_wr = 1'b0, cfg_start = 1'b0, cfg_irq_en = 1'b0, irq_clr = 1'b0;
    logic [1:0]    state_code;
    logic          start_bit, irq_en, irq_flag;
    logic [CW-1:0] pulse_count;

    int total = 0;
    int bad   = 0;
    logic [CW-1:0] saved;

    always #(CLK_PERIOD/2) clk = ~clk;

    autobaud_meter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_irq_en(cfg_irq_en),
        .irq_clr(irq_clr), .state_code(state_code), .start_bit(start_bit),
        .irq_en(irq_en), .irq_flag(irq_flag), .pulse_count(pulse_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic s, input logic ie);
        cfg_wr = 1'b1; cfg_start = s; cfg_irq_en = ie;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0; cfg_irq_en = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic low_pulse(input int n);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "status", state_code, 0);
        check("R1", "start", start_bit, 0);
        check("R1", "ie", irq_en, 0);
        check("R1", "flag", irq_flag, 0);
        check("R1", "count", pulse_count, 0);
    endtask

    task automatic t_wake();
        cfg(1'b0, 1'b0);
        check("R2", "status after empty write", state_code, 0);
        cfg(1'b0, 1'b1);
        check("R2", "status after ie write", state_code, 1);
        check("R2", "ie loaded", irq_en, 1);
        check("R2", "start stays clear", start_bit, 0);
    endtask

    task automatic t_basic();
        cfg(1'b1, 1'b1);
        check("R3", "armed start", start_bit, 1);
        check("R3", "armed status", state_code, 1);
        low_pulse(5);
        check("R4", "count for 5", pulse_count, 5);
        check("R6", "status back to ready", state_code, 1);
        check("R6", "start self-cleared", start_bit, 0);
        check("R7", "flag set with ie", irq_flag, 1);
        clear_irq();
        check("R8", "flag cleared by w1c", irq_flag, 0);
    endtask

    task automatic t_hold_prev();
        cfg(1'b1, 1'b1);
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R3", "counting status", state_code, 2);
        check("R5", "count holds previous", pulse_count, 5);
        repeat (34) @(negedge clk);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R4", "count for 37", pulse_count, 37);
        clear_irq();
    endtask

    task automatic t_irq_off();
        cfg(1'b1, 1'b0);
        low_pulse(9);
        check("R7", "count latched with ie off", pulse_count, 9);
        check("R7", "flag stays clear", irq_flag, 0);
    endtask

    task automatic t_detached();
        cfg(1'b1, 1'b1);
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        cfg(1'b0, 1'b1);
        check("R9", "still counting after clear", state_code, 2);
        check("R9", "start reads clear", start_bit, 0);
        repeat (2) @(negedge clk);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", "status after orphan rise", state_code, 2);
        check("R9", "irq on orphan rise", irq_flag, 1);
        check("R9", "count not updated", pulse_count, 9);
        clear_irq();
        low_pulse(3);
        check("R9", "irq on second orphan rise", irq_flag, 1);
        check("R9", "status still counting", state_code, 2);
        clear_irq();
        cfg(1'b1, 1'b1);
        check("R9", "start restored", start_bit, 1);
        low_pulse(3);
        check("R9", "finished after reattach", state_code, 1);
        check("R9", "new result differs", int'(pulse_count != 8'd9), 1);
        clear_irq();
    endtask

    task automatic t_disarm();
        saved = pulse_count;
        cfg(1'b1, 1'b1);
        cfg(1'b0, 1'b1);
        check("R10", "disarmed status", state_code, 1);
        check("R10", "disarmed start", start_bit, 0);
        low_pulse(4);
        check("R10", "status ignores pulse", state_code, 1);
        check("R10", "count ignores pulse", pulse_count, saved);
        check("R10", "no irq", irq_flag, 0);
    endtask

    task automatic t_saturate();
        cfg(1'b1, 1'b1);
        low_pulse(300);
        check("R11", "saturated count", pulse_count, 255);
        clear_irq();
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wake();
        t_basic();
        t_hold_prev();
        t_irq_off();
        t_detached();
        t_disarm();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule